// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block keeps the event status, interrupt-enable mask and DMA-enable state of a serial-bus host controller. Neighbouring logic reports events by pulsing single-cycle set strobes. The unit combines the enabled pending events into one interrupt line. It also raises a receive DMA request and a transmit DMA request from the receive-ready and transmit-ready flags, but only for the directions whose DMA is enabled.

Software reaches the state through a small register port with four selectable registers. Each write takes effect at a clock edge, and reads return data combinationally. A parameter picks one of two revisions, which behave differently:
- On the older revision (REV below 0x34), reading the vector register returns the 1-based position of the lowest pending enabled event and acknowledges that event. Status writes are ignored on this revision.
- On the newer revision, the vector register always reads as zero. Status bits 0, 1, 2 and 5 can instead be cleared by writing ones to them.

Top module: `irq_status_vector`

## Requirements
- R1: After reset, status, mask and DMA registers read zero, and irq, dma_rx_req and dma_tx_req are low.
- R2: A set strobe bit latches only at stored status positions 1, 2, 3, 4, 9, 10, 11 and 15 (mask 0x8E1E). Strobes at other positions are ignored.
- R3: A status read (reg_sel=1) returns bit 12 equal to the live bus_busy input. The stored status bits appear at their own positions.
- R4: irq is high exactly when status AND mask is nonzero.
- R5: On the older revision, a vector read (reg_sel=2) returns the 1-based index of the lowest set bit of status AND mask, or 0 when there is none. A nonzero result clears that status bit at the clock edge of the read.
- R6: On the newer revision, the vector register reads 0 and reading it changes no status bit.
- R7: On the newer revision, a status write clears exactly the status bits where (written value AND 0x27) is 1. RRDY (bit 3) and XRDY (bit 4) are never cleared by software.
- R8: On the older revision, status writes leave status unchanged.
- R9: A mask write (reg_sel=0) keeps bits 4:0 on the older revision and bits 5:0 on the newer one.
- R10: A DMA register write (reg_sel=3) keeps only bit 15 (receive enable) and bit 7 (transmit enable).
- R11: A DMA write with bit 15 set clears mask bit 3. A DMA write with bit 7 set clears mask bit 4.
- R12: dma_rx_req equals status bit 3 while receive DMA is enabled and is low otherwise. dma_tx_req equals status bit 4 while transmit DMA is enabled and is low otherwise.
- R13: When a set strobe and a software clear (a status write or a vector acknowledge) hit the same bit in the same cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the vector acknowledge) |
| reg_sel | input | 2 | Register select: 0 mask, 1 status, 2 vector, 3 DMA |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for reg_sel |
| evt_set | input | 16 | Single-cycle event set strobes, one per status bit |
| bus_busy | input | 1 | Live bus-busy flag shown at status bit 12 |
| irq | output | 1 | Combined interrupt |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
Every register update lands at the clock edge that samples the strobe. Because irq, both DMA requests and reg_rdata are combinational from state, they show the new value in the cycle after that edge. The one exception is the vector value, which appears in the same cycle as the read strobe, before the acknowledge clears its bit. The bench updates its model at each rising edge and compares a quarter period later, while the inputs driven at the previous falling edge are still applied. Directed checks look at the vector value just after the falling edge where the read is driven. They look at the results of writes at the falling edge after the write's rising edge.

// File: rtl/irq_sv_pkg.sv
package irq_sv_pkg;
    localparam int          STAT_W      = 16;
    localparam int          B_RRDY      = 3;
    localparam int          B_XRDY      = 4;
    localparam int          B_BUSY      = 12;
    localparam int          DMA_RX_EN   = 15;
    localparam int          DMA_TX_EN   = 7;
    localparam logic [15:0] STORE_BITS  = 16'h8E1E;
    localparam logic [15:0] W1C_BITS    = 16'h0027;
    localparam logic [15:0] DMA_BITS    = 16'h8080;
    localparam logic [15:0] RDY_BITS    = 16'h0018;
    localparam logic [7:0]  NEW_REV_MIN = 8'h34;

    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_STAT = 2'd1,
        SEL_VEC  = 2'd2,
        SEL_DMA  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [STAT_W-1:0] mask;
        logic [STAT_W-1:0] dma;
    } isv_state_t;
endpackage

// File: rtl/irq_vec_lowest.sv
module irq_vec_lowest #(
    parameter int W  = 16,
    parameter int IW = $clog2(W + 1)
) (
    input  logic [W-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          hit
);
    // scan from the top so the lowest set bit is written last
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i + 1);
        end
    end

    assign hit = |req;

    always_comb begin
        if (hit) a_r5_idx_nonzero: assert (idx != '0);
    end
endmodule

// File: rtl/irq_dma_req.sv
module irq_dma_req #(
    parameter int N = 2
) (
    input  logic [N-1:0] en,
    input  logic [N-1:0] rdy,
    output logic [N-1:0] req
);
    for (genvar g = 0; g < N; g++) begin : g_dir
        assign req[g] = en[g] & rdy[g];
    end
endmodule

// File: rtl/irq_status_vector.sv
module irq_status_vector
    import irq_sv_pkg::*;
#(
    parameter logic [7:0] REV = 8'h11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic [15:0] evt_set,
    input  logic        bus_busy,
    output logic        irq,
    output logic        dma_rx_req,
    output logic        dma_tx_req
);
    localparam bit          NEW_REV   = (REV >= NEW_REV_MIN);
    localparam logic [15:0] MASK_KEEP = NEW_REV ? 16'h003F : 16'h001F;
    localparam int          IDX_W     = $clog2(STAT_W + 1);

    isv_state_t        st_q, st_d;
    logic [STAT_W-1:0] pend;
    logic [IDX_W-1:0]  vec_idx;
    logic              vec_hit;
    logic [STAT_W-1:0] vec_oh;
    logic [STAT_W-1:0] clr;
    logic              wr_mask, wr_stat, wr_dma, rd_vec;
    logic [1:0]        dma_req;

    assign wr_mask = reg_wr && (reg_sel == SEL_MASK);
    assign wr_stat = reg_wr && (reg_sel == SEL_STAT);
    assign wr_dma  = reg_wr && (reg_sel == SEL_DMA);
    assign rd_vec  = reg_rd && (reg_sel == SEL_VEC);

    assign pend = st_q.status & st_q.mask;

    irq_vec_lowest #(.W(STAT_W), .IW(IDX_W)) u_lowest (
        .req (pend),
        .idx (vec_idx),
        .hit (vec_hit)
    );

    assign vec_oh = vec_hit ? (STAT_W'(1) << (vec_idx - IDX_W'(1))) : '0;

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (NEW_REV && wr_stat)            clr = clr | (reg_wdata & W1C_BITS);
        if (!NEW_REV && rd_vec && vec_hit) clr = clr | vec_oh;
        // set strobes win over any clear in the same cycle
        st_d.status = ((st_q.status & ~clr) | evt_set) & STORE_BITS;
        if (wr_mask) st_d.mask = reg_wdata & MASK_KEEP;
        if (wr_dma) begin
            st_d.dma = reg_wdata & DMA_BITS;
            if (reg_wdata[DMA_RX_EN]) st_d.mask[B_RRDY] = 1'b0;
            if (reg_wdata[DMA_TX_EN]) st_d.mask[B_XRDY] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (reg_sel_e'(reg_sel))
            SEL_MASK: reg_rdata = st_q.mask;
            SEL_STAT: reg_rdata = st_q.status | (STAT_W'(bus_busy) << B_BUSY);
            SEL_VEC:  reg_rdata = NEW_REV ? '0 : STAT_W'(vec_idx);
            SEL_DMA:  reg_rdata = st_q.dma;
        endcase
    end

    irq_dma_req #(.N(2)) u_dma (
        .en  ({st_q.dma[DMA_TX_EN], st_q.dma[DMA_RX_EN]}),
        .rdy ({st_q.status[B_XRDY], st_q.status[B_RRDY]}),
        .req (dma_req)
    );

    assign dma_rx_req = dma_req[0];
    assign dma_tx_req = dma_req[1];
    assign irq        = |pend;

    a_r5_vec_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!NEW_REV && rd_vec && vec_hit && evt_set == '0)
        |=> ((st_q.status & $past(vec_oh)) == '0));

    a_r7_rdy_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> (($past(st_q.status) & ~st_q.status & RDY_BITS) == '0));

    a_r8_old_readonly: assert property (@(posedge clk) disable iff (!rst_n)
        (!NEW_REV && wr_stat && evt_set == '0) |=> $stable(st_q.status));

    a_r11_rx_dma_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dma && reg_wdata[DMA_RX_EN]) |=> !st_q.mask[B_RRDY]);

    a_r11_tx_dma_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dma && reg_wdata[DMA_TX_EN]) |=> !st_q.mask[B_XRDY]);

    a_r13_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_set & STORE_BITS))
        |=> ((st_q.status & $past(evt_set & STORE_BITS)) == $past(evt_set & STORE_BITS)));
endmodule

// File: tb/irq_status_vector_bench.sv
module irq_status_vector_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, bus_busy = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0, evt_set = '0;
    logic [15:0] rd_o, rd_n;
    logic        irq_o, irq_n, rx_o, rx_n, tx_o, tx_n;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] m_stat [2];
    logic [15:0] m_mask [2];
    logic [15:0] m_dma  [2];
    logic [15:0] t_pend, t_clr;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_status_vector u_irq_status_vector (
        .clk, .rst_n, .reg_wr, .reg_rd, .reg_sel, .reg_wdata,
        .reg_rdata(rd_o), .evt_set, .bus_busy,
        .irq(irq_o), .dma_rx_req(rx_o), .dma_tx_req(tx_o)
    );

    irq_status_vector #(.REV(8'h34)) u_irq_status_vector_new (
        .clk, .rst_n, .reg_wr, .reg_rd, .reg_sel, .reg_wdata,
        .reg_rdata(rd_n), .evt_set, .bus_busy,
        .irq(irq_n), .dma_rx_req(rx_n), .dma_tx_req(tx_n)
    );

    function automatic logic [15:0] lowest(input logic [15:0] v);
        for (int i = 0; i < 16; i++) if (v[i]) return 16'(i + 1);
        return 16'd0;
    endfunction

    function automatic logic [15:0] exp_rd(input int k);
        case (reg_sel)
            2'd0:    return m_mask[k];
            2'd1:    return m_stat[k] | (16'(bus_busy) << 12);
            2'd2:    return (k == 0) ? lowest(m_stat[k] & m_mask[k]) : 16'd0;
            default: return m_dma[k];
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // behavioural reference: k=0 older revision, k=1 newer revision
    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                m_stat[k] = '0; m_mask[k] = '0; m_dma[k] = '0;
            end else begin
                t_pend = m_stat[k] & m_mask[k];
                t_clr  = '0;
                if (reg_wr && reg_sel == 2'd1 && k == 1) t_clr = reg_wdata & 16'h0027;
                if (reg_rd && reg_sel == 2'd2 && k == 0 && t_pend != 0)
                    t_clr[lowest(t_pend) - 1] = 1'b1;
                if (reg_wr && reg_sel == 2'd0)
                    m_mask[k] = reg_wdata & ((k == 0) ? 16'h001F : 16'h003F);
                if (reg_wr && reg_sel == 2'd3) begin
                    m_dma[k] = reg_wdata & 16'h8080;
                    if (reg_wdata[15]) m_mask[k][3] = 1'b0;
                    if (reg_wdata[7])  m_mask[k][4] = 1'b0;
                end
                m_stat[k] = ((m_stat[k] & ~t_clr) | evt_set) & 16'h8E1E;
            end
        end
    end

    // per-clock comparison against the model
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && !done) begin
            chk("R4 irq old",    16'(irq_o), 16'(|(m_stat[0] & m_mask[0])));
            chk("R4 irq new",    16'(irq_n), 16'(|(m_stat[1] & m_mask[1])));
            chk("R12 rx old",    16'(rx_o),  16'(m_dma[0][15] & m_stat[0][3]));
            chk("R12 tx new",    16'(tx_n),  16'(m_dma[1][7] & m_stat[1][4]));
            chk("R3 rdata old",  rd_o, exp_rd(0));
            chk("R3 rdata new",  rd_n, exp_rd(1));
        end
    end

    task automatic cyc(input logic wr, input logic rd, input logic [1:0] sel,
                       input logic [15:0] wd, input logic [15:0] set);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = wd; evt_set = set;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; evt_set = '0;
    endtask

    task automatic peek(input logic [1:0] sel);
        reg_sel = sel;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        peek(2'd0); chk("R1 mask old", rd_o, 16'h0); chk("R1 mask new", rd_n, 16'h0);
        peek(2'd1); chk("R1 stat old", rd_o, 16'h0); chk("R1 stat new", rd_n, 16'h0);
        peek(2'd3); chk("R1 dma old", rd_o, 16'h0);
        chk("R1 irq", 16'({irq_o, irq_n, rx_o, tx_o}), 16'h0);

        // R2 / R3: all strobes, only stored bits latch; busy bit live
        cyc(1'b0, 1'b0, 2'd1, 16'h0, 16'hFFFF);
        bus_busy = 1'b1;
        peek(2'd1); chk("R2 R3 stat old busy", rd_o, 16'h9E1E); chk("R3 stat new busy", rd_n, 16'h9E1E);
        bus_busy = 1'b0;
        peek(2'd1); chk("R3 stat idle", rd_o, 16'h8E1E);
        chk("R12 rx low while disabled", 16'(rx_o), 16'h0);

        // R9 mask width, R4 irq
        cyc(1'b1, 1'b0, 2'd0, 16'hFFFF, 16'h0);
        peek(2'd0); chk("R9 mask old", rd_o, 16'h001F); chk("R9 mask new", rd_n, 16'h003F);
        chk("R4 irq raised", 16'({irq_o, irq_n}), 16'h3);

        // R5 / R6 vector read
        @(negedge clk);
        reg_rd = 1'b1; reg_sel = 2'd2;
        #1;
        chk("R5 vec old", rd_o, 16'd2); chk("R6 vec new", rd_n, 16'd0);
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        peek(2'd1); chk("R5 ack cleared", rd_o, 16'h8E1C); chk("R6 no clear", rd_n, 16'h8E1E);

        // R7 / R8 status write
        cyc(1'b1, 1'b0, 2'd1, 16'hFFFF, 16'h0);
        peek(2'd1); chk("R8 old ro", rd_o, 16'h8E1C); chk("R7 w1c new", rd_n, 16'h8E18);

        // R10 / R11 / R12 DMA enable
        cyc(1'b1, 1'b0, 2'd3, 16'hFFFF, 16'h0);
        peek(2'd3); chk("R10 dma old", rd_o, 16'h8080); chk("R10 dma new", rd_n, 16'h8080);
        peek(2'd0); chk("R11 mask old", rd_o, 16'h0007); chk("R11 mask new", rd_n, 16'h0027);
        chk("R12 reqs on", 16'({rx_o, tx_o, rx_n, tx_n}), 16'hF);
        cyc(1'b1, 1'b0, 2'd3, 16'h0080, 16'h0);
        chk("R12 rx off tx on", 16'({rx_o, tx_o, rx_n, tx_n}), 16'h5);

        // R13 set beats clear
        cyc(1'b1, 1'b0, 2'd1, 16'h0002, 16'h0002);
        peek(2'd1); chk("R13 new set wins", rd_n, 16'h8E1A); chk("R13 old", rd_o, 16'h8E1E);

        // R5 vector for bit 4, ack drops transmit request
        cyc(1'b1, 1'b0, 2'd0, 16'h0010, 16'h0);
        @(negedge clk);
        reg_rd = 1'b1; reg_sel = 2'd2;
        #1;
        chk("R5 vec bit4", rd_o, 16'd5);
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        peek(2'd1); chk("R5 bit4 cleared", rd_o, 16'h8E0E);
        chk("R12 tx follows ack", 16'({tx_o, tx_n}), 16'h1);

        // R5 empty vector
        cyc(1'b1, 1'b0, 2'd0, 16'h0000, 16'h0);
        cyc(1'b0, 1'b1, 2'd2, 16'h0, 16'h0);
        peek(2'd2); chk("R5 vec none", rd_o, 16'd0);
        chk("R4 irq low", 16'({irq_o, irq_n}), 16'h0);
        peek(2'd1); chk("R5 empty no clear", rd_o, 16'h8E0E);

        repeat (2) @(posedge clk);
        #(CLK_PERIOD/2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule